// File: doc/BRIEF.md
# I/O Window Decoder for Legacy Peripheral Functions

This block turns configuration register contents into chip selects for six legacy peripheral functions that sit behind one host I/O bus: a floppy controller, a parallel port, two serial ports, an auxiliary single-byte port and a general-purpose I/O pair. Five of the functions take their window base from a pair of configuration bytes, a high byte and a low byte. The decoder forces each base onto the window's natural alignment and rejects any base outside the legal range. It then gates the window with that function's activation bits. The GPIO pair has no base registers. Its start address comes from a two-bit code plus an enable bit held in a global control byte.

Each cycle the host's 16-bit I/O address is compared against every live window. When windows overlap, a fixed priority picks a single winner, so at most one select is raised. In the same cycle, each interrupt selection byte of the four interrupt-capable functions is turned into a one-hot routing mask over sixteen interrupt lines. Selects and routing masks are registered. Both reflect the address and configuration seen at the previous rising clock edge.

Top module: `ldd_top`

## Requirements
- R1: While `rst_n` is low, `dev_sel` and `irq_route` are all zero. Once out of reset, both outputs show the inputs sampled at the previous rising edge (one cycle of latency).
- R2: The floppy (index 0) and serial (indexes 2 and 3) bases are `{base_hi, base_lo}` with bits 2:0 cleared, and each window spans 8 bytes. A window is legal only when its aligned base lies between 0x0100 and 0x0FF8 inclusive.
- R3: The parallel (index 1) base is `{base_hi, base_lo}` with bits 1:0 cleared, and the window spans 4 bytes. It is legal only for aligned bases from 0x0100 to 0x0FFC inclusive.
- R4: The auxiliary (index 4) window is 1 byte at `{base_hi, base_lo}` with no alignment. It is legal for bases from 0x0100 to 0x0FFF. It needs only `loc_act[4]` and ignores `glb_en`.
- R5: The floppy, parallel, serial 1 and serial 2 windows decode only when the matching `loc_act` bit is set and the matching `glb_en` bit is set. The `glb_en` bits are 0, 3, 4 and 5 respectively.
- R6: The GPIO window (select index 5) is 2 bytes long and is live only when `gpio_ctrl[7]` is set. Its base is picked by `gpio_ctrl[1:0]`: 0 gives 0x00E0, 1 gives 0x00E2, 2 gives 0x00E4 and 3 gives 0x00EA.
- R7: Windows are matched on all 16 address bits, so an address that differs from a window only above bit 11 does not select it.
- R8: `dev_sel` bit positions are 0 floppy, 1 parallel, 2 serial 1, 3 serial 2, 4 auxiliary and 5 GPIO. At most one bit is set. Where windows overlap, the lowest index wins.
- R9: `irq_route[i]`, for i = 0 floppy, 1 parallel, 2 serial 1, 3 serial 2, has only bit `irq_num[i]` set when `irq_num[i]` is 15 or less. When `irq_num[i]` is above 15, the mask is all zero.
- R10: A window whose aligned base is outside its legal range, or whose enables are not met, never raises its select, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| glb_en | input | 8 | Global function enable byte (bits 0, 3, 4, 5 used) |
| gpio_ctrl | input | 8 | GPIO control byte: bit 7 enable, bits 1:0 base code |
| loc_act | input | 5 | Local activation bit per based window, indexed as dev_sel |
| base_hi | input | 5x8 | High base byte per based window |
| base_lo | input | 5x8 | Low base byte per based window |
| irq_num | input | 4x8 | Interrupt selection per interrupt-capable function |
| dev_sel | output | 6 | Registered one-hot-or-zero chip selects |
| irq_route | output | 4x16 | Registered one-hot-or-zero interrupt routing masks |

## Verification
The embedded assertions check these properties on every cycle: the select vector is one-hot or zero, a window that was illegal or disabled on the previous edge raises no select, the highest-priority hit always wins, and reset clears both outputs. Each routing mask is also checked to be one-hot or zero, with an out-of-range parallel interrupt giving an empty mask. Only the bench's sweeps can show that window edges, alignment masking, the range limits, the GPIO base codes and full-width address matching land on the exact addresses the requirements name. The sweeps do this by comparing every address over several configurations against an arithmetic model.

// File: rtl/ldd_pkg.sv
package ldd_pkg;
  localparam int ADDR_W    = 16;
  localparam int REG_W     = 8;
  localparam int NUM_BASED = 5;
  localparam int NUM_DEV   = NUM_BASED + 1;
  localparam int NUM_IRQ   = 4;
  localparam int IRQ_LINES = 16;
  localparam int IRQ_SEL_W = $clog2(IRQ_LINES);

  localparam int DEV_FDC  = 0;
  localparam int DEV_PAR  = 1;
  localparam int DEV_SER1 = 2;
  localparam int DEV_SER2 = 3;
  localparam int DEV_AUX  = 4;
  localparam int DEV_GPIO = 5;

  localparam int LEGAL_LO  = 'h0100;
  localparam int LEGAL_END = 'h1000;  // first address past the legal space
  localparam int GPIO_LEN_BITS = 1;

  // log2 of the window length for each based window
  function automatic int win_len_bits(input int dev);
    case (dev)
      DEV_PAR: return 2;
      DEV_AUX: return 0;
      default: return 3;
    endcase
  endfunction

  // highest legal aligned base: the window must end inside the legal space
  function automatic int win_max_base(input int dev);
    return LEGAL_END - (1 << win_len_bits(dev));
  endfunction

  function automatic bit win_needs_glb(input int dev);
    return dev != DEV_AUX;
  endfunction

  function automatic int win_glb_bit(input int dev);
    case (dev)
      DEV_FDC:  return 0;
      DEV_PAR:  return 3;
      DEV_SER1: return 4;
      DEV_SER2: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] base_join(input logic [REG_W-1:0] hi,
                                                  input logic [REG_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [ADDR_W-1:0] base_align(input logic [ADDR_W-1:0] base,
                                                   input int len_bits);
    logic [ADDR_W-1:0] keep;
    keep = '1;
    keep = keep << len_bits;
    return base & keep;
  endfunction

  function automatic logic addr_in_window(input logic [ADDR_W-1:0] addr,
                                          input logic [ADDR_W-1:0] base,
                                          input int len_bits);
    return (addr >> len_bits) == (base >> len_bits);
  endfunction

  function automatic logic [ADDR_W-1:0] gpio_base(input logic [1:0] code);
    case (code)
      2'd0:    return ADDR_W'('h00E0);
      2'd1:    return ADDR_W'('h00E2);
      2'd2:    return ADDR_W'('h00E4);
      default: return ADDR_W'('h00EA);
    endcase
  endfunction

  function automatic logic [IRQ_LINES-1:0] irq_onehot(input logic [REG_W-1:0] num);
    if (num > REG_W'(IRQ_LINES - 1)) return '0;
    return IRQ_LINES'(1) << num[IRQ_SEL_W-1:0];
  endfunction

  // lowest index wins
  function automatic logic [NUM_DEV-1:0] pick_first(input logic [NUM_DEV-1:0] hits);
    logic [NUM_DEV-1:0] grant;
    grant = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--)
      if (hits[i]) grant = NUM_DEV'(1) << i;
    return grant;
  endfunction
endpackage

// File: rtl/ldd_window.sv
module ldd_window
  import ldd_pkg::*;
#(
  parameter int LEN_BITS  = 3,
  parameter int MAX_BASE  = 'h0FF8,
  parameter bit NEEDS_GLB = 1'b1
) (
  input  logic [REG_W-1:0]  base_hi,
  input  logic [REG_W-1:0]  base_lo,
  input  logic              glb_on,
  input  logic              loc_on,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              legal,
  output logic              enabled
);
  localparam logic [ADDR_W-1:0] MIN_B = ADDR_W'(LEGAL_LO);
  localparam logic [ADDR_W-1:0] MAX_B = ADDR_W'(MAX_BASE);

  logic [ADDR_W-1:0] aligned;

  assign aligned = base_align(base_join(base_hi, base_lo), LEN_BITS);
  assign legal   = (aligned >= MIN_B) && (aligned <= MAX_B);
  assign enabled = loc_on && (glb_on || !NEEDS_GLB);
  assign hit     = enabled && legal && addr_in_window(addr, aligned, LEN_BITS);
endmodule

// File: rtl/ldd_gpio_window.sv
module ldd_gpio_window
  import ldd_pkg::*;
(
  input  logic              gpio_on,
  input  logic [1:0]        code,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [ADDR_W-1:0] start;

  assign start = gpio_base(code);
  assign hit   = gpio_on && addr_in_window(addr, start, GPIO_LEN_BITS);
endmodule

// File: rtl/ldd_prio.sv
module ldd_prio
  import ldd_pkg::*;
(
  input  logic [NUM_DEV-1:0] hits,
  output logic [NUM_DEV-1:0] grant
);
  assign grant = pick_first(hits);
endmodule

// File: rtl/ldd_top.sv
module ldd_top
  import ldd_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [ADDR_W-1:0]                    io_addr,
  input  logic [REG_W-1:0]                     glb_en,
  input  logic [REG_W-1:0]                     gpio_ctrl,
  input  logic [NUM_BASED-1:0]                 loc_act,
  input  logic [NUM_BASED-1:0][REG_W-1:0]      base_hi,
  input  logic [NUM_BASED-1:0][REG_W-1:0]      base_lo,
  input  logic [NUM_IRQ-1:0][REG_W-1:0]        irq_num,
  output logic [NUM_DEV-1:0]                   dev_sel,
  output logic [NUM_IRQ-1:0][IRQ_LINES-1:0]    irq_route
);
  // named internal events, observed by the assertions below
  logic [NUM_DEV-1:0]                win_hit;
  logic [NUM_BASED-1:0]              win_legal;
  logic [NUM_BASED-1:0]              win_enabled;
  logic [NUM_DEV-1:0]                grant;
  logic [NUM_IRQ-1:0][IRQ_LINES-1:0] route_d;

  logic unused_bits;
  assign unused_bits = ^{glb_en[7:6], glb_en[2:1], gpio_ctrl[6:2]};

  for (genvar d = 0; d < NUM_BASED; d++) begin : g_win
    localparam int GB = win_glb_bit(d);
    ldd_window #(
      .LEN_BITS (win_len_bits(d)),
      .MAX_BASE (win_max_base(d)),
      .NEEDS_GLB(win_needs_glb(d))
    ) i_win (
      .base_hi(base_hi[d]),
      .base_lo(base_lo[d]),
      .glb_on (glb_en[GB]),
      .loc_on (loc_act[d]),
      .addr   (io_addr),
      .hit    (win_hit[d]),
      .legal  (win_legal[d]),
      .enabled(win_enabled[d])
    );
  end

  ldd_gpio_window i_gpio (
    .gpio_on(gpio_ctrl[7]),
    .code   (gpio_ctrl[1:0]),
    .addr   (io_addr),
    .hit    (win_hit[DEV_GPIO])
  );

  ldd_prio i_prio (
    .hits (win_hit),
    .grant(grant)
  );

  for (genvar q = 0; q < NUM_IRQ; q++) begin : g_irq
    assign route_d[q] = irq_onehot(irq_num[q]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_sel   <= '0;
      irq_route <= '0;
    end else begin
      dev_sel   <= grant;
      irq_route <= route_d;
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (dev_sel == '0) && (irq_route == '0));

  // R8
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel));

  // R8
  floppy_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(win_hit[DEV_FDC]) |-> dev_sel[DEV_FDC]);

  // R5
  floppy_glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(glb_en[0]) |-> !dev_sel[DEV_FDC]);

  // R4
  aux_local_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(loc_act[DEV_AUX]) |-> !dev_sel[DEV_AUX]);

  // R6
  gpio_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(gpio_ctrl[7]) |-> !dev_sel[DEV_GPIO]);

  for (genvar d = 0; d < NUM_BASED; d++) begin : g_win_chk
    // R10
    dead_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !($past(win_legal[d]) && $past(win_enabled[d]))
      |-> !dev_sel[d]);
  end

  for (genvar q = 0; q < NUM_IRQ; q++) begin : g_irq_chk
    // R9
    irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_route[q]));
  end

  // R9
  par_irq_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(irq_num[DEV_PAR]) > 8'd15) |-> (irq_route[DEV_PAR] == '0));
endmodule

// File: tb/test_ldd_top.sv
module test_ldd_top;
  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [15:0]           io_addr = '0;
  logic [7:0]            glb_en = '0;
  logic [7:0]            gpio_ctrl = '0;
  logic [4:0]            loc_act = '0;
  logic [4:0][7:0]       base_hi = '0;
  logic [4:0][7:0]       base_lo = '0;
  logic [3:0][7:0]       irq_num = '0;
  logic [5:0]            dev_sel;
  logic [3:0][15:0]      irq_route;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ldd_top i_ldd_top (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .glb_en(glb_en),
    .gpio_ctrl(gpio_ctrl), .loc_act(loc_act), .base_hi(base_hi),
    .base_lo(base_lo), .irq_num(irq_num), .dev_sel(dev_sel), .irq_route(irq_route)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [15:0] b0, input logic [15:0] b1,
                         input logic [15:0] b2, input logic [15:0] b3,
                         input logic [15:0] b4, input logic [4:0] act,
                         input logic [7:0] g, input logic [7:0] gc);
    logic [15:0] b [5];
    b = '{b0, b1, b2, b3, b4};
    for (int d = 0; d < 5; d++) begin
      base_hi[d] = b[d][15:8];
      base_lo[d] = b[d][7:0];
    end
    loc_act = act; glb_en = g; gpio_ctrl = gc;
  endtask

  // arithmetic model: window start by integer rounding, membership by range
  function automatic logic [5:0] exp_sel(input int a);
    logic [5:0] r = '0;
    bit on [6];
    for (int d = 0; d < 5; d++) begin
      int raw = int'(base_hi[d]) * 256 + int'(base_lo[d]);
      int ln  = (d == 1) ? 4 : ((d == 4) ? 1 : 8);
      int st  = raw - (raw % ln);
      bit lg  = (st >= 256) && (st + ln <= 4096);
      bit gl  = (d == 0) ? glb_en[0] : (d == 1) ? glb_en[3] :
                (d == 2) ? glb_en[4] : (d == 3) ? glb_en[5] : 1'b1;
      on[d] = loc_act[d] && gl && lg && (a >= st) && (a < st + ln);
    end
    begin
      int g;
      case (gpio_ctrl[1:0])
        2'd0: g = 224;
        2'd1: g = 226;
        2'd2: g = 228;
        default: g = 234;
      endcase
      on[5] = gpio_ctrl[7] && (a >= g) && (a < g + 2);
    end
    for (int d = 0; d < 6; d++)
      if (on[d] && r == '0) r[d] = 1'b1;
    return r;
  endfunction

  // called at a falling edge; each address is checked one edge later
  task automatic sweep(input string req, input int lo, input int hi);
    for (int a = lo; a <= hi; a++) begin
      io_addr = 16'(a);
      @(posedge clk);
      @(negedge clk);
      chk(req, 64'(dev_sel), 64'(exp_sel(a)));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs low even with a matching address
    set_cfg(16'h03F0, 16'h0378, 16'h03F8, 16'h02F8, 16'h0280, 5'b11111, 8'h39, 8'h83);
    io_addr = 16'h03F0;
    for (int q = 0; q < 4; q++) irq_num[q] = 8'(3 + q);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", 64'(dev_sel), 64'h0);
    chk("R1", 64'(irq_route), 64'h0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", 64'(dev_sel), 64'h01);
    // R1: one cycle of latency, old value holds until the edge
    io_addr = 16'h0378;
    #2;
    chk("R1", 64'(dev_sel), 64'h01);
    @(posedge clk); @(negedge clk);
    chk("R1", 64'(dev_sel), 64'h02);

    // R7: typical layout, sweep includes aliases above bit 11
    sweep("R7", 0, 'h13FF);
    // R2 / R3: unaligned bases are rounded down
    set_cfg(16'h03F5, 16'h037B, 16'h03FF, 16'h02F9, 16'h0281, 5'b11111, 8'h39, 8'h83);
    sweep("R2", 0, 'h13FF);
    // R3: range edges for the 4- and 8-byte windows
    set_cfg(16'h0100, 16'h0FFC, 16'h0FF0, 16'h0108, 16'h0FF8, 5'b11111, 8'h39, 8'h82);
    sweep("R3", 0, 'h13FF);
    // R10: out-of-range bases, auxiliary at its top edge
    set_cfg(16'h00F8, 16'h1000, 16'h10F8, 16'h00FF, 16'h0FFF, 5'b11111, 8'h39, 8'h03);
    sweep("R10", 0, 'h13FF);
    // R8: overlapping windows resolve by priority
    set_cfg(16'h0300, 16'h0304, 16'h0300, 16'h0300, 16'h0302, 5'b11111, 8'h39, 8'h80);
    sweep("R8", 0, 'h13FF);
    // R5: global and local enables both required
    set_cfg(16'h03F0, 16'h0378, 16'h03F8, 16'h02F8, 16'h0280, 5'b01101, 8'h28, 8'h00);
    sweep("R5", 0, 'h0FFF);
    // R4: auxiliary ignores the global byte
    set_cfg(16'h03F0, 16'h0378, 16'h03F8, 16'h02F8, 16'h0280, 5'b11111, 8'h00, 8'h00);
    sweep("R4", 'h0200, 'h03FF);
    // R6: every GPIO code, then disabled
    for (int c = 0; c < 4; c++) begin
      gpio_ctrl = 8'h80 | 8'(c);
      sweep("R6", 0, 'h01FF);
    end
    gpio_ctrl = 8'h03;
    sweep("R6", 0, 'h01FF);

    // R9: interrupt routing across and beyond the 16 lines
    for (int v = 0; v < 21; v++) begin
      for (int q = 0; q < 4; q++) irq_num[q] = 8'(v + q);
      @(posedge clk); @(negedge clk);
      for (int q = 0; q < 4; q++)
        chk("R9", 64'(irq_route[q]), (v + q < 16) ? (64'h1 << (v + q)) : 64'h0);
    end
    for (int q = 0; q < 4; q++) irq_num[q] = 8'hFF;
    @(posedge clk); @(negedge clk);
    for (int q = 0; q < 4; q++) chk("R9", 64'(irq_route[q]), 64'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule